// File: doc/BRIEF.md
# Drive Power Mode Controller

This block keeps track of which of four power modes a storage device is in (active, idle, standby or sleep) and drives the enables for the head actuator driver and the spindle motor driver to match. Command strobes from the command decoder arrive already classified as ordinary commands, standby requests, immediate standby requests or sleep requests. Separate strobes report that a command has finished, that the power-on sequence has finished, that a device reset sequence has finished, and that a device reset has been received.

Any ordinary command or device reset wakes the block to active. Finishing that work drops it back to idle on its own. A standby request parks both drivers. A sleep request parks them and shuts out everything except a device reset, which brings the device back only as far as standby. When automatic power-down is enabled, an inactivity timer counts idle clock ticks and forces standby once a programmable timeout has passed. The timeout is expressed in clock ticks per minute times a number of minutes. The ticks-per-minute parameter can be shrunk so that the timer runs in simulation.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high and on the first cycle after it, the mode is active: `mode_code` = 0, `mode_oh` = 4'b0001, and both enables are high.
- R2: A strobe on `cmd_done`, `por_done` or `rst_seq_done` while active moves the mode to idle on the next clock edge. The same strobes leave idle and standby unchanged.
- R3: A device reset (`dev_reset`), or a command with `cmd_kind` = 2'b00 (ordinary command), moves the mode to active from idle or standby on the next edge.
- R4: A command with `cmd_kind` = 2'b01 (standby) or 2'b10 (immediate standby), issued in active or idle, moves the mode to standby on the next edge.
- R5: With `apd_en` high, the mode moves from idle to standby exactly TIMEOUT_MIN × TICKS_PER_MIN edges after idle was entered, provided no command or device reset arrives in that time. Dropping `apd_en` for a cycle restarts the count.
- R6: With `apd_en` low, idle is never left because of elapsed time.
- R7: A command with `cmd_kind` = 2'b11 (sleep) moves the mode to sleep from active, idle or standby on the next edge.
- R8: In sleep, commands and completion strobes have no effect. A device reset moves sleep to standby, not to active.
- R9: `actuator_en` and `spindle_en` are high in active and idle, and low in standby and sleep. They change on the same edge as the mode.
- R10: `mode_code` encodes active = 0, idle = 1, standby = 2 and sleep = 3. `mode_oh` has exactly the bit at index `mode_code` set.
- R11: Inputs that arrive in the same cycle are ranked in this order: a device reset first, then a command strobe, then a completion strobe, then the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| cmd_valid | input | 1 | One-cycle strobe: a command was issued |
| cmd_kind | input | 2 | Command class: 00 ordinary, 01 standby, 10 immediate standby, 11 sleep |
| cmd_done | input | 1 | Strobe: the current non-power command finished |
| por_done | input | 1 | Strobe: the power-on sequence finished |
| rst_seq_done | input | 1 | Strobe: a device reset sequence finished |
| dev_reset | input | 1 | Strobe: a device reset was received |
| apd_en | input | 1 | Automatic power-down enable |
| mode_code | output | 2 | Current mode, binary coded |
| mode_oh | output | 4 | Current mode, one-hot |
| actuator_en | output | 1 | Head actuator driver enable |
| spindle_en | output | 1 | Spindle driver enable |

## Verification
Every input strobe changes the registered mode and enables on the first rising edge after it, so each expected mode is due exactly one cycle after its stimulus. Inputs are driven on the falling edge, and the outputs are compared 2 ns after the following rising edge. The timeout is due TIMEOUT_MIN × TICKS_PER_MIN edges after idle is entered. The bench drives one expected item per cycle across the whole window, so an expiry that comes one cycle early or one cycle late shows up as a mismatch on a specific cycle. Same-cycle collisions between a device reset, a command and a completion strobe are driven on purpose to check the ranking.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int NUM_MODES = 4;
  localparam int MODE_W    = $clog2(NUM_MODES);

  typedef enum logic [MODE_W-1:0] {
    PM_ACTIVE  = 2'd0,
    PM_IDLE    = 2'd1,
    PM_STANDBY = 2'd2,
    PM_SLEEP   = 2'd3
  } pm_state_t;

  typedef enum logic [1:0] {
    CK_ORDINARY = 2'b00,
    CK_STANDBY  = 2'b01,
    CK_STBY_NOW = 2'b10,
    CK_SLEEP    = 2'b11
  } cmd_kind_t;

  // Drivers are powered only in the two working modes
  function automatic logic drivers_on(pm_state_t s);
    return (s == PM_ACTIVE) || (s == PM_IDLE);
  endfunction

endpackage

// File: rtl/pmc_idle_timer.sv
module pmc_idle_timer #(
  parameter longint unsigned LIMIT = 64'd20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!expire) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pmc_next_state.sv
module pmc_next_state
  import pwr_mode_pkg::*;
(
  input  pm_state_t cur,
  input  logic      cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic      any_done,
  input  logic      dev_reset,
  input  logic      tmo,
  output pm_state_t nxt
);
  cmd_kind_t kind;
  assign kind = cmd_kind_t'(cmd_kind);

  always_comb begin
    nxt = cur;
    if (cur == PM_SLEEP) begin
      if (dev_reset) nxt = PM_STANDBY;
    end else if (dev_reset) begin
      nxt = PM_ACTIVE;
    end else if (cmd_valid) begin
      unique case (kind)
        CK_ORDINARY:          nxt = PM_ACTIVE;
        CK_STANDBY, CK_STBY_NOW: nxt = PM_STANDBY;
        CK_SLEEP:             nxt = PM_SLEEP;
        default:              nxt = cur;
      endcase
    end else if (cur == PM_ACTIVE && any_done) begin
      nxt = PM_IDLE;
    end else if (cur == PM_IDLE && tmo) begin
      nxt = PM_STANDBY;
    end
  end
endmodule

// File: rtl/pmc_state_reg.sv
module pmc_state_reg
  import pwr_mode_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  pm_state_t            nxt,
  output pm_state_t            cur,
  output logic [NUM_MODES-1:0] oh,
  output logic                 act_en,
  output logic                 spin_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur     <= PM_ACTIVE;
      act_en  <= 1'b1;
      spin_en <= 1'b1;
    end else begin
      cur     <= nxt;
      act_en  <= drivers_on(nxt);
      spin_en <= drivers_on(nxt);
    end
  end

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_oh
    always_ff @(posedge clk) begin
      if (rst) oh[i] <= (i == 0);
      else     oh[i] <= (MODE_W'(nxt) == MODE_W'(i));
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter longint unsigned TICKS_PER_MIN = 64'd6_000_000_000,
  parameter int unsigned     TIMEOUT_MIN   = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_kind,
  input  logic       cmd_done,
  input  logic       por_done,
  input  logic       rst_seq_done,
  input  logic       dev_reset,
  input  logic       apd_en,
  output logic [1:0] mode_code,
  output logic [3:0] mode_oh,
  output logic       actuator_en,
  output logic       spindle_en
);
  localparam longint unsigned TIMEOUT_TICKS = TICKS_PER_MIN * longint'(TIMEOUT_MIN);

  pm_state_t cur, nxt;
  logic      tmo, run;

  assign run = (cur == PM_IDLE) && apd_en && !cmd_valid && !dev_reset;

  pmc_idle_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
    .clk(clk), .rst(rst), .run(run), .expire(tmo)
  );

  pmc_next_state u_next (
    .cur(cur), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .any_done(cmd_done | por_done | rst_seq_done),
    .dev_reset(dev_reset), .tmo(tmo), .nxt(nxt)
  );

  pmc_state_reg u_reg (
    .clk(clk), .rst(rst), .nxt(nxt), .cur(cur), .oh(mode_oh),
    .act_en(actuator_en), .spin_en(spindle_en)
  );

  assign mode_code = cur;
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter longint unsigned TICKS_PER_MIN = 64'd6_000_000_000,
  parameter int unsigned     TIMEOUT_MIN   = 30
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [1:0] cmd_kind,
  input logic       dev_reset,
  input logic       apd_en,
  input logic [1:0] mode_code,
  input logic [3:0] mode_oh,
  input logic       actuator_en,
  input logic       spindle_en
);
  localparam longint unsigned TICKS = TICKS_PER_MIN * longint'(TIMEOUT_MIN);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic          quiet;
  logic [CW-1:0] win_q;
  assign quiet = (mode_code == 2'd1) && apd_en && !cmd_valid && !dev_reset;

  always_ff @(posedge clk) begin
    if (rst || !quiet) win_q <= '0;
    else if (win_q != LAST) win_q <= win_q + 1'b1;
  end

  // R10
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(mode_oh) == 1) && mode_oh[mode_code]);

  // R9
  drv_off_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code[1] == 1'b1) |-> (!actuator_en && !spindle_en));

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code == 2'd3 && !dev_reset) |=> (mode_code == 2'd3));

  // R8
  sleep_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code == 2'd3 && dev_reset) |=> (mode_code == 2'd2));

  // R3
  reset_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code != 2'd3 && dev_reset) |=> (mode_code == 2'd0));

  // R4
  stby_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_code[1] && cmd_valid && !dev_reset && (cmd_kind == 2'b01 || cmd_kind == 2'b10))
    |=> (mode_code == 2'd2));

  // R5
  early_tmo_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && win_q != LAST) |=> (mode_code == 2'd1));

  // R5
  tmo_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (quiet && win_q == LAST) |=> (mode_code == 2'd2));

  // R6
  no_apd_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_code == 2'd1 && !apd_en && !cmd_valid && !dev_reset) |=> (mode_code == 2'd1));
endmodule

bind pwr_mode_ctrl pmc_chk #(.TICKS_PER_MIN(TICKS_PER_MIN), .TIMEOUT_MIN(TIMEOUT_MIN)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .dev_reset(dev_reset), .apd_en(apd_en), .mode_code(mode_code),
  .mode_oh(mode_oh), .actuator_en(actuator_en), .spindle_en(spindle_en)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  localparam longint unsigned TPM  = 64'd4;
  localparam int unsigned     TMIN = 5;
  localparam int              T    = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, cmd_valid = 0, cmd_done = 0, por_done = 0, rst_seq_done = 0;
  logic dev_reset = 0, apd_en = 0;
  logic [1:0] cmd_kind = 2'b00;
  logic [1:0] mode_code;
  logic [3:0] mode_oh;
  logic actuator_en, spindle_en;

  pwr_mode_ctrl #(.TICKS_PER_MIN(TPM), .TIMEOUT_MIN(TMIN)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_done(cmd_done), .por_done(por_done), .rst_seq_done(rst_seq_done),
    .dev_reset(dev_reset), .apd_en(apd_en), .mode_code(mode_code),
    .mode_oh(mode_oh), .actuator_en(actuator_en), .spindle_en(spindle_en)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  logic [1:0] m_st = 2'd0;
  int         m_cnt = 0;

  task automatic compare(logic [1:0] e, string tag);
    logic [3:0] e_oh;
    logic       e_en;
    e_oh = 4'b0001 << e;
    e_en = (e < 2'd2);
    n_chk++;
    if (mode_code !== e || mode_oh !== e_oh || actuator_en !== e_en || spindle_en !== e_en) begin
      n_err++;
      $display("FAIL %s: code=%0d oh=%b act=%b spin=%b, expected code=%0d oh=%b act=%b spin=%b",
               tag, mode_code, mode_oh, actuator_en, spindle_en, e, e_oh, e_en, e_en);
    end
  endtask

  // Driver: one stimulus per cycle, expected mode pushed to the scoreboard
  task automatic step(bit cv, logic [1:0] ck, bit cd, bit pd, bit rd, bit dr, bit ap, string tag);
    logic [1:0] nx;
    @(negedge clk);
    cmd_valid = cv; cmd_kind = ck; cmd_done = cd; por_done = pd;
    rst_seq_done = rd; dev_reset = dr; apd_en = ap;
    if (m_st == 2'd3)                             nx = dr ? 2'd2 : 2'd3;
    else if (dr)                                  nx = 2'd0;
    else if (cv)                                  nx = (ck == 2'b00) ? 2'd0 : (ck == 2'b11) ? 2'd3 : 2'd2;
    else if (m_st == 2'd0 && (cd || pd || rd))    nx = 2'd1;
    else if (m_st == 2'd1 && ap && m_cnt == T-1)  nx = 2'd2;
    else                                          nx = m_st;
    m_cnt = (m_st == 2'd1 && ap && !cv && !dr) ? m_cnt + 1 : 0;
    m_st  = nx;
    exp_q.push_back(nx);
    tag_q.push_back(tag);
  endtask

  task automatic quiet(int n, bit ap, string tag);
    for (int i = 0; i < n; i++) step(0, 2'b00, 0, 0, 0, 0, ap, tag);
  endtask

  // Monitor: pops one expected item per rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(2'd0, "R1 in reset");
    rst = 1'b0;
    @(posedge clk); #2;
    compare(2'd0, "R1 after reset");

    step(0, 2'b00, 0, 1, 0, 0, 0, "R2 power-on done to idle");
    step(0, 2'b00, 1, 0, 0, 0, 0, "R2 done ignored in idle");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R3 ordinary cmd from idle");
    step(0, 2'b00, 1, 0, 0, 0, 0, "R2 cmd done to idle");
    step(1, 2'b01, 0, 0, 0, 0, 0, "R4 standby cmd from idle, R9 drivers off");
    step(0, 2'b00, 1, 1, 1, 0, 0, "R2 completions ignored in standby");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R3 ordinary cmd from standby");
    step(0, 2'b00, 0, 0, 1, 0, 0, "R2 reset sequence done to idle");
    step(1, 2'b10, 0, 0, 0, 0, 0, "R4 immediate standby from idle");
    step(0, 2'b00, 0, 0, 0, 1, 0, "R3 device reset from standby");
    step(1, 2'b01, 0, 0, 0, 0, 0, "R4 standby cmd from active");
    step(1, 2'b11, 0, 0, 0, 0, 0, "R7 sleep from standby");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R8 ordinary cmd ignored in sleep");
    step(1, 2'b01, 0, 0, 0, 0, 0, "R8 standby cmd ignored in sleep");
    step(0, 2'b00, 1, 1, 1, 0, 1, "R8 completions ignored in sleep");
    quiet(T + 2, 1, "R8 no timeout in sleep");
    step(0, 2'b00, 0, 0, 0, 1, 0, "R8 device reset wakes to standby");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R3 wake");
    step(1, 2'b11, 0, 0, 0, 0, 0, "R7 sleep from active");
    step(0, 2'b00, 0, 0, 0, 1, 0, "R8 reset to standby");
    step(1, 2'b00, 0, 0, 0, 0, 0, "R3 wake again");
    step(0, 2'b00, 1, 0, 0, 0, 0, "R2 to idle");
    step(1, 2'b11, 0, 0, 0, 0, 0, "R7 sleep from idle");
    step(0, 2'b00, 0, 0, 0, 1, 0, "R8 reset to standby");
    step(1, 2'b11, 0, 0, 0, 1, 0, "R11 reset beats sleep cmd");
    step(1, 2'b00, 1, 0, 0, 0, 0, "R11 cmd beats completion");
    step(1, 2'b01, 0, 0, 0, 1, 0, "R11 reset beats standby cmd");
    step(0, 2'b00, 1, 0, 0, 0, 1, "R2 to idle with power-down on");
    quiet(T - 1, 1, "R5 idle before timeout");
    quiet(1, 1, "R5 timeout to standby");
    step(1, 2'b00, 0, 0, 0, 0, 1, "R3 wake");
    step(0, 2'b00, 1, 0, 0, 0, 1, "R2 idle");
    quiet(10, 1, "R5 partial count");
    quiet(1, 0, "R6 disable restarts count");
    quiet(T - 1, 1, "R5 idle after restart");
    quiet(1, 1, "R5 timeout after restart");
    step(0, 2'b00, 0, 0, 0, 1, 0, "R3 wake");
    step(0, 2'b00, 1, 0, 0, 0, 0, "R2 idle");
    quiet(3 * T, 0, "R6 no timeout when disabled");

    @(negedge clk);
    cmd_valid = 0; cmd_done = 0; dev_reset = 0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule